// File: doc/BRIEF.md
# Nybble ALU with Carry-Chain Flags

This block is the purely combinational arithmetic and logic unit of a small processor whose data path is one nybble (4 bits) wide. Each evaluation takes a source operand, a target operand, the current carry flag and a 3-bit operation code. It returns a result that is meant to be written back into the target. It also returns four status flags and a write mask that tells the surrounding control logic which of those flags the operation updates.

Add and subtract always include the carry. A plain add is obtained by clearing the carry first. A plain subtract is obtained by setting it first, because the carry acts as an inverted borrow. The two rotates also pass through the carry, so that wider shifts can be composed from several nybble steps. Compare writes no result and only produces flags. Deciding what happens when the target is itself a status register is left to the caller.

Top module: `nybble_alu`

## Requirements
- R1: With op_i=0 (add with carry), res_o equals (tgt_i + src_i + carry_i) mod 16, and flag C equals the carry out of bit 3.
- R2: With op_i=1 (subtract with borrow), res_o equals (src_i + ~tgt_i + carry_i) mod 16, that is src_i - tgt_i - (1 - carry_i). Flag C is 1 exactly when no borrow occurs.
- R3: For op_i 0 and 1, flag O is 1 exactly when the two's-complement result falls outside -8..7. This holds when the two operands fed to the adder (the target being inverted for subtract) have equal sign bits and the result's sign bit differs from them.
- R4: Whenever res_valid_o is 1, flag Z is 1 exactly when res_o is 0000, and flag N equals res_o bit 3.
- R5: With op_i=2, 3 and 4, res_o is the bitwise AND, OR and XOR of the operands, and the write mask is 0011 (only Z and N).
- R6: With op_i=5 (rotate left through carry), res_o is {tgt_i[2:0], carry_i} and C is tgt_i[3].
- R7: With op_i=6 (rotate right through carry), res_o is {carry_i, tgt_i[3:1]} and C is tgt_i[0].
- R8: With op_i=7 (unsigned compare), Z is 1 only when src_i equals tgt_i, and C is 1 only when src_i is greater than tgt_i. The write mask is 0110, res_valid_o is 0, and res_o repeats tgt_i.
- R9: flg_o and flg_we_o are packed as bit 3 = O, bit 2 = C, bit 1 = Z, bit 0 = N. Add and subtract use a mask of 1111, and the two rotates use 0111. Every flag bit outside the mask is driven 0.
- R10: res_valid_o is 1 for every operation other than compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 4 | Source operand |
| tgt_i | input | 4 | Target operand, also the rotate operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 3 | Operation code, 0..7 as listed in the requirements |
| res_o | output | 4 | Result to be written to the target |
| res_valid_o | output | 1 | Result is meant to be written back |
| flg_o | output | 4 | New flag values {O,C,Z,N} |
| flg_we_o | output | 4 | Flag write mask {O,C,Z,N} |

## Verification
The checks assume that every input carries a defined 0 or 1 value whenever the outputs are examined. They also assume that op_i carries only the eight defined codes, which is automatic because every 3-bit value is one of them. The stimulus never drives X or Z. It changes all four inputs together, away from the sampling point, and it draws operands, carry and operation uniformly over their complete ranges, so no illegal combination can occur. Directed vectors are added on top of the random ones to hit the signed-overflow, wrap, borrow and equality edges.

// File: rtl/nybble_alu_pkg.sv
package nybble_alu_pkg;

    localparam int unsigned NYB_W   = 4;
    localparam int unsigned OP_W    = 3;
    localparam int unsigned FLAG_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADC = 3'd0,
        OP_SBB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_ROL = 3'd5,
        OP_ROR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic o;
        logic c;
        logic z;
        logic n;
    } alu_flags_t;

    typedef enum logic [1:0] {
        LOG_AND = 2'd0,
        LOG_OR  = 2'd1,
        LOG_XOR = 2'd2
    } log_sel_e;

    localparam alu_flags_t MASK_ARITH = '{o: 1'b1, c: 1'b1, z: 1'b1, n: 1'b1};
    localparam alu_flags_t MASK_ROT   = '{o: 1'b0, c: 1'b1, z: 1'b1, n: 1'b1};
    localparam alu_flags_t MASK_LOGIC = '{o: 1'b0, c: 1'b0, z: 1'b1, n: 1'b1};
    localparam alu_flags_t MASK_CMP   = '{o: 1'b0, c: 1'b1, z: 1'b1, n: 1'b0};

    function automatic alu_flags_t mask_for(input alu_op_e op);
        alu_flags_t m;
        case (op)
            OP_ADC, OP_SBB:         m = MASK_ARITH;
            OP_ROL, OP_ROR:         m = MASK_ROT;
            OP_AND, OP_OR, OP_XOR:  m = MASK_LOGIC;
            default:                m = MASK_CMP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/nybble_arith.sv
module nybble_arith
    import nybble_alu_pkg::*;
#(
    parameter int unsigned W = NYB_W
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] tgt_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] opb;
    logic [W:0]   wide;

    always_comb begin
        opb    = sub_i ? ~tgt_i : tgt_i;
        wide   = {1'b0, src_i} + {1'b0, opb} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        ovf_o  = (src_i[MSB] == opb[MSB]) && (wide[MSB] != src_i[MSB]);
    end
endmodule

// File: rtl/nybble_logic.sv
module nybble_logic
    import nybble_alu_pkg::*;
#(
    parameter int unsigned W = NYB_W
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] tgt_i,
    input  log_sel_e     sel_i,
    output logic [W-1:0] res_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            case (sel_i)
                LOG_AND: res_o[b] = src_i[b] & tgt_i[b];
                LOG_OR:  res_o[b] = src_i[b] | tgt_i[b];
                default: res_o[b] = src_i[b] ^ tgt_i[b];
            endcase
        end
    end
endmodule

// File: rtl/nybble_rotate.sv
module nybble_rotate
    import nybble_alu_pkg::*;
#(
    parameter int unsigned W = NYB_W
) (
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    input  logic         left_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int unsigned MSB = W - 1;

    always_comb begin
        if (left_i) begin
            res_o  = {val_i[MSB-1:0], cin_i};
            cout_o = val_i[MSB];
        end else begin
            res_o  = {cin_i, val_i[MSB:1]};
            cout_o = val_i[0];
        end
    end
endmodule

// File: rtl/nybble_compare.sv
module nybble_compare
    import nybble_alu_pkg::*;
#(
    parameter int unsigned W = NYB_W
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] tgt_i,
    output logic         eq_o,
    output logic         gt_o
);
    always_comb begin
        eq_o = (src_i == tgt_i);
        gt_o = (src_i > tgt_i);
    end
endmodule

// File: rtl/nybble_alu.sv
module nybble_alu
    import nybble_alu_pkg::*;
#(
    parameter int unsigned W = NYB_W
) (
    input  logic [W-1:0]      src_i,
    input  logic [W-1:0]      tgt_i,
    input  logic              carry_i,
    input  logic [OP_W-1:0]   op_i,
    output logic [W-1:0]      res_o,
    output logic              res_valid_o,
    output logic [FLAG_W-1:0] flg_o,
    output logic [FLAG_W-1:0] flg_we_o
);
    localparam int unsigned MSB = W - 1;

    alu_op_e    op;
    log_sel_e   lsel;
    logic [W-1:0] ar_sum, lg_res, rt_res;
    logic       ar_cout, ar_ovf, rt_cout, cp_eq, cp_gt;
    alu_flags_t fl, we;
    logic [W-1:0] res;

    assign op = alu_op_e'(op_i);

    always_comb begin
        case (op)
            OP_AND:  lsel = LOG_AND;
            OP_OR:   lsel = LOG_OR;
            default: lsel = LOG_XOR;
        endcase
    end

    nybble_arith #(.W(W)) u_arith (
        .src_i  (src_i),
        .tgt_i  (tgt_i),
        .cin_i  (carry_i),
        .sub_i  (op == OP_SBB),
        .sum_o  (ar_sum),
        .cout_o (ar_cout),
        .ovf_o  (ar_ovf)
    );

    nybble_logic #(.W(W)) u_logic (
        .src_i (src_i),
        .tgt_i (tgt_i),
        .sel_i (lsel),
        .res_o (lg_res)
    );

    nybble_rotate #(.W(W)) u_rot (
        .val_i  (tgt_i),
        .cin_i  (carry_i),
        .left_i (op == OP_ROL),
        .res_o  (rt_res),
        .cout_o (rt_cout)
    );

    nybble_compare #(.W(W)) u_cmp (
        .src_i (src_i),
        .tgt_i (tgt_i),
        .eq_o  (cp_eq),
        .gt_o  (cp_gt)
    );

    always_comb begin
        fl = '0;
        we = mask_for(op);
        case (op)
            OP_ADC, OP_SBB: begin
                res  = ar_sum;
                fl.c = ar_cout;
                fl.o = ar_ovf;
            end
            OP_ROL, OP_ROR: begin
                res  = rt_res;
                fl.c = rt_cout;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res = lg_res;
            end
            default: begin
                res  = tgt_i;
                fl.c = cp_gt;
                fl.z = cp_eq;
            end
        endcase
        if (op != OP_CMP) begin
            fl.z = (res == '0);
            fl.n = res[MSB];
        end
        fl = fl & we;
    end

    assign res_o       = res;
    assign res_valid_o = (op != OP_CMP);
    assign flg_o       = fl;
    assign flg_we_o    = we;
endmodule

// File: rtl/nybble_alu_chk.sv
module nybble_alu_chk
    import nybble_alu_pkg::*;
#(
    parameter int unsigned W = NYB_W
) (
    input logic [W-1:0]      src_i,
    input logic [W-1:0]      tgt_i,
    input logic              carry_i,
    input logic [OP_W-1:0]   op_i,
    input logic [W-1:0]      res_o,
    input logic              res_valid_o,
    input logic [FLAG_W-1:0] flg_o,
    input logic [FLAG_W-1:0] flg_we_o
);
    logic [W:0] add_ref;
    assign add_ref = {1'b0, src_i} + {1'b0, tgt_i} + {{W{1'b0}}, carry_i};

    always_comb begin
        p_unmasked_zero_r9: assert ((flg_o & ~flg_we_o) == '0)
            else $error("flag set outside its write mask");
        if (res_valid_o) begin
            p_zero_flag_r4: assert ((flg_o[1]) == (res_o == '0))
                else $error("Z does not match result");
            p_neg_flag_r4: assert (flg_o[0] == res_o[W-1])
                else $error("N does not match result msb");
        end
        if (op_i == 3'd7) begin
            p_cmp_nowrite_r8: assert (!res_valid_o && res_o == tgt_i)
                else $error("compare produced a result write");
        end else begin
            p_valid_r10: assert (res_valid_o)
                else $error("result not valid for writing op");
        end
        if (op_i == 3'd0) begin
            p_add_sum_r1: assert ({flg_o[2], res_o} == add_ref)
                else $error("add sum or carry wrong");
        end
    end
endmodule

bind nybble_alu nybble_alu_chk #(.W(W)) u_chk (
    .src_i       (src_i),
    .tgt_i       (tgt_i),
    .carry_i     (carry_i),
    .op_i        (op_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .flg_o       (flg_o),
    .flg_we_o    (flg_we_o)
);

// File: tb/sim_nybble_alu.sv
module sim_nybble_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src, tgt;
    logic       cin;
    logic [2:0] op;
    logic [3:0] res, flg, we;
    logic       vld;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    nybble_alu u0 (
        .src_i (src), .tgt_i (tgt), .carry_i (cin), .op_i (op),
        .res_o (res), .res_valid_o (vld), .flg_o (flg), .flg_we_o (we)
    );

    function automatic string tag_of(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int sx(input int v);
        return (v >= 8) ? v - 16 : v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s op=%0d src=%h tgt=%h c=%0d actual=%h expected=%h",
                     tag, op, src, tgt, cin, act, exp);
        end
    endtask

    task automatic run(input int o, input int s, input int t, input int c);
        int r, m, fc, fo, fz, fn, sum, sv, ev;
        @(negedge clk);
        op = o[2:0]; src = s[3:0]; tgt = t[3:0]; cin = c[0];
        fo = 0; fc = 0; ev = 1;
        case (o)
            0: begin
                sum = t + s + c; r = sum & 15; fc = sum >> 4; m = 15;
                sv = sx(s) + sx(t) + c; fo = (sv > 7 || sv < -8) ? 1 : 0;
            end
            1: begin
                sum = s - t - (1 - c); r = (sum + 32) & 15; fc = (sum >= 0) ? 1 : 0; m = 15;
                sv = sx(s) - sx(t) - (1 - c); fo = (sv > 7 || sv < -8) ? 1 : 0;
            end
            2: begin r = s & t; m = 3; end
            3: begin r = s | t; m = 3; end
            4: begin r = s ^ t; m = 3; end
            5: begin r = ((t << 1) | c) & 15; fc = t >> 3; m = 7; end
            6: begin r = (t >> 1) | (c << 3); fc = t & 1; m = 7; end
            default: begin r = t; fc = (s > t) ? 1 : 0; m = 6; ev = 0; end
        endcase
        if (o == 7) begin
            fz = (s == t) ? 1 : 0; fn = 0;
        end else begin
            fz = (r == 0) ? 1 : 0; fn = r >> 3;
        end
        #2;
        chk(tag_of(o), int'(res), r);
        chk((o == 0 || o == 1) ? "R3/R4" : "R4", int'(flg), ((fo << 3) | (fc << 2) | (fz << 1) | fn) & m);
        chk("R9", int'(we), m);
        chk("R10", int'(vld), ev);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int seed_dummy;
        src = '0; tgt = '0; cin = 1'b0; op = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // initial quiet state: add 0+0+0 gives zero with Z set (R1, R4)
        run(0, 0, 0, 0);
        // R3 positive overflow, R1 wrap with carry
        run(0, 1, 7, 0);
        run(0, 1, 15, 0);
        run(0, 15, 15, 1);
        // R2 borrow and no-borrow, R3 subtract overflow
        run(1, 0, 1, 1);
        run(1, 5, 5, 1);
        run(1, 5, 5, 0);
        run(1, 8, 1, 1);
        run(1, 7, 8, 1);
        // R5 logic ops ignore carry
        run(2, 12, 10, 1);
        run(3, 0, 0, 1);
        run(4, 9, 9, 1);
        // R6 / R7 rotate edges
        run(5, 0, 8, 0);
        run(5, 0, 0, 1);
        run(6, 0, 1, 1);
        run(6, 0, 1, 0);
        // R8 compare equal, greater, less
        run(7, 6, 6, 0);
        run(7, 9, 3, 1);
        run(7, 3, 9, 1);
        run(7, 15, 0, 0);
        seed_dummy = $urandom(32'd2024);
        for (int i = 0; i < 3000; i++) begin
            run(int'($urandom_range(7, 0)), int'($urandom_range(15, 0)),
                int'($urandom_range(15, 0)), int'($urandom_range(1, 0)));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule